// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster timing for a parallel LCD panel: a horizontal sync, a vertical sync and a data-enable qualifier. It also pulses three events that interrupt logic can latch: frame start, vsync start and vsync end. Four packed timing words describe the raster. Each word carries a total or position value in its low half and an active or width value in its high half. Horizontal values count in groups of eight dot clocks. Vertical values count in lines.

Software programs the timing words and the polarity selects, then raises the run request. The generator latches every word at the start and again at each frame boundary, so a word rewritten mid-frame changes nothing until the next frame begins. A two-bit power-state output confirms whether the raster is running. Pixel fetch, dot-clock division and panel power sequencing are left to neighbouring blocks.

Top module: `lcd_raster_timer`

## Requirements
- R1: While `runReq` is low, `pwrState` reads 0, no event pulses, and the syncs and enable sit at their inactive levels. One clock edge after `runReq` is sampled high, `pwrState` reads 3 and the raster begins at dot 0 of line 0. One edge after it is sampled low, the raster stops.
- R2: A line lasts 8 × H-total dots, where H-total is bits [15:0] of `horizWord`. The dot counter runs from 0 to 8 × H-total − 1, then the next line begins.
- R3: A frame lasts V-total lines, where V-total is bits [15:0] of `vertWord`. `frameStart` is high for exactly one dot, at dot 0 of line 0.
- R4: The enable is active while the dot is below 8 × `horizWord[31:16]` and the line is below `vertWord[31:16]`.
- R5: Horizontal sync is active from dot 8 × `hsyncWord[15:0]` up to, but not including, dot 8 × (`hsyncWord[15:0]` + `hsyncWord[31:16]`).
- R6: Vertical sync is active on lines `vsyncWord[15:0]` up to, but not including, line `vsyncWord[15:0]` + `vsyncWord[31:16]`. That sum must stay below V-total.
- R7: `vsStart` pulses at dot 0 of the first vertical-sync line. `vsEnd` pulses at dot 0 of the first line after the vertical sync.
- R8: Setting `syncPol[2]` makes vertical sync active low. Setting `syncPol[1]` makes horizontal sync active low. Setting `syncPol[0]` makes the enable active low.
- R9: The timing words and `syncPol` are sampled only when the raster starts and on the last dot of each frame. Changes at any other time take effect at the next frame start.
- R10: After reset, every output is low and `pwrState` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rstN | input | 1 | Active-low asynchronous reset |
| runReq | input | 1 | Run request; high runs the raster |
| syncPol | input | 3 | Active-low selects: [2] vsync, [1] hsync, [0] enable |
| horizWord | input | 32 | [15:0] line total /8, [31:16] active dots /8 |
| hsyncWord | input | 32 | [15:0] hsync start /8, [31:16] hsync width /8 |
| vertWord | input | 32 | [15:0] total lines, [31:16] active lines |
| vsyncWord | input | 32 | [15:0] vsync start line, [31:16] vsync width in lines |
| hsyncOut | output | 1 | Horizontal sync |
| vsyncOut | output | 1 | Vertical sync |
| deOut | output | 1 | Data enable |
| frameStart | output | 1 | One-dot pulse at dot 0 of line 0 |
| vsStart | output | 1 | One-dot pulse when vertical sync begins |
| vsEnd | output | 1 | One-dot pulse on the line after vertical sync |
| pwrState | output | 2 | 3 while running, 0 while stopped |

## Verification
The bench builds the block with its default parameters: 16-bit halves and a three-bit dot shift, which gives eight dots per horizontal unit. It then programs very small rasters: three or two units per line and six lines per frame. A whole frame therefore lasts 144 or 96 clocks, and every edge of every window can be sampled within a few frames. The bench rewrites the polarity in the middle of a frame and the geometry between runs. These steps reach the frame-boundary latching and the polarity inversion, including the inverted idle levels after a stop.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;
  // control-to-datapath strobes
  typedef struct packed {
    logic countEn;     // counters advance
    logic loadShadow;  // capture timing words and polarity
  } rasterStrobe_t;

  localparam int POL_V_IDX = 2;
  localparam int POL_H_IDX = 1;
  localparam int POL_D_IDX = 0;
endpackage

// File: rtl/lcd_raster_ctrl.sv
module lcd_raster_ctrl
  import lcd_raster_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          runReq,
  input  logic          lastDot,
  output rasterStrobe_t strobe,
  output logic [1:0]    pwrState
);
  logic running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) running <= 1'b0;
    else       running <= runReq;
  end

  always_comb begin
    strobe.countEn    = running;
    // latch on the start edge or on the final dot of a frame
    strobe.loadShadow = runReq & (~running | lastDot);
    pwrState          = running ? 2'b11 : 2'b00;
  end

  // R1
  start_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'b00 && runReq) |=> (pwrState == 2'b11));
endmodule

// File: rtl/lcd_raster_count.sv
module lcd_raster_count
  import lcd_raster_pkg::*;
#(
  parameter int HALF_W    = 16,
  parameter int DOT_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  rasterStrobe_t     strobe,
  input  logic [2:0]        syncPol,
  input  logic [2*HALF_W-1:0] horizWord,
  input  logic [2*HALF_W-1:0] hsyncWord,
  input  logic [2*HALF_W-1:0] vertWord,
  input  logic [2*HALF_W-1:0] vsyncWord,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              deOut,
  output logic              frameStart,
  output logic              vsStart,
  output logic              vsEnd,
  output logic              lastDot
);
  localparam int HCNT_W = HALF_W + DOT_SHIFT;
  localparam logic [DOT_SHIFT-1:0] DOT_ZERO = '0;

  // latched timing
  logic [HALF_W-1:0] hTot, hAct, hsPos, hsWid;
  logic [HALF_W-1:0] vTot, vAct, vsPos, vsWid;
  logic [2:0]        polShadow;

  logic [HCNT_W-1:0] hCnt;
  logic [HALF_W-1:0] vCnt;

  logic [HCNT_W-1:0] hEnd;
  logic [HCNT_W:0]   hsLo, hsHi, hCntX;
  logic [HALF_W:0]   vsHiLine;
  logic              lineEnd, frameEnd;
  logic              hsAct, vsAct, deAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hTot <= '0; hAct <= '0; hsPos <= '0; hsWid <= '0;
      vTot <= '0; vAct <= '0; vsPos <= '0; vsWid <= '0;
      polShadow <= '0;
    end else if (strobe.loadShadow) begin
      hTot  <= horizWord[HALF_W-1:0];
      hAct  <= horizWord[2*HALF_W-1:HALF_W];
      hsPos <= hsyncWord[HALF_W-1:0];
      hsWid <= hsyncWord[2*HALF_W-1:HALF_W];
      vTot  <= vertWord[HALF_W-1:0];
      vAct  <= vertWord[2*HALF_W-1:HALF_W];
      vsPos <= vsyncWord[HALF_W-1:0];
      vsWid <= vsyncWord[2*HALF_W-1:HALF_W];
      polShadow <= syncPol;
    end
  end

  always_comb begin
    hEnd     = {hTot, DOT_ZERO} - HCNT_W'(1);
    lineEnd  = (hCnt == hEnd);
    frameEnd = (vCnt == vTot - HALF_W'(1));
    lastDot  = strobe.countEn & lineEnd & frameEnd;

    hCntX    = {1'b0, hCnt};
    hsLo     = {1'b0, hsPos, DOT_ZERO};
    hsHi     = {({1'b0, hsPos} + {1'b0, hsWid}), DOT_ZERO};
    vsHiLine = {1'b0, vsPos} + {1'b0, vsWid};

    hsAct = strobe.countEn && (hCntX >= hsLo) && (hCntX < hsHi);
    vsAct = strobe.countEn && (vCnt >= vsPos) && ({1'b0, vCnt} < vsHiLine);
    deAct = strobe.countEn && (hCnt < {hAct, DOT_ZERO}) && (vCnt < vAct);

    hsyncOut = hsAct ^ polShadow[POL_H_IDX];
    vsyncOut = vsAct ^ polShadow[POL_V_IDX];
    deOut    = deAct ^ polShadow[POL_D_IDX];

    frameStart = strobe.countEn && (hCnt == '0) && (vCnt == '0);
    vsStart    = strobe.countEn && (hCnt == '0) && (vCnt == vsPos);
    vsEnd      = strobe.countEn && (hCnt == '0) && ({1'b0, vCnt} == vsHiLine);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (!strobe.countEn) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (lineEnd) begin
      hCnt <= '0;
      vCnt <= frameEnd ? '0 : vCnt + HALF_W'(1);
    end else begin
      hCnt <= hCnt + HCNT_W'(1);
    end
  end

  // R3
  fs_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart);
  // R1
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.countEn |=> (hCnt == '0 && vCnt == '0));
  // R7
  vss_in_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vsStart && vsWid != '0) |-> vsAct);
  // R2
  hcnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.countEn |-> (hCnt <= hEnd));
endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
  import lcd_raster_pkg::*;
#(
  parameter int HALF_W    = 16,
  parameter int DOT_SHIFT = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                runReq,
  input  logic [2:0]          syncPol,
  input  logic [2*HALF_W-1:0] horizWord,
  input  logic [2*HALF_W-1:0] hsyncWord,
  input  logic [2*HALF_W-1:0] vertWord,
  input  logic [2*HALF_W-1:0] vsyncWord,
  output logic                hsyncOut,
  output logic                vsyncOut,
  output logic                deOut,
  output logic                frameStart,
  output logic                vsStart,
  output logic                vsEnd,
  output logic [1:0]          pwrState
);
  rasterStrobe_t strobe;
  logic          lastDot;

  lcd_raster_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .runReq(runReq), .lastDot(lastDot),
    .strobe(strobe), .pwrState(pwrState)
  );

  lcd_raster_count #(.HALF_W(HALF_W), .DOT_SHIFT(DOT_SHIFT)) u_count (
    .clk(clk), .rstN(rstN), .strobe(strobe), .syncPol(syncPol),
    .horizWord(horizWord), .hsyncWord(hsyncWord),
    .vertWord(vertWord), .vsyncWord(vsyncWord),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut),
    .frameStart(frameStart), .vsStart(vsStart), .vsEnd(vsEnd),
    .lastDot(lastDot)
  );
endmodule

// File: tb/lcd_raster_timer_bench.sv
module lcd_raster_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runReq = 1'b0;
  logic [2:0]  syncPol = 3'b000;
  logic [31:0] horizWord, hsyncWord, vertWord, vsyncWord;
  logic        hsyncOut, vsyncOut, deOut, frameStart, vsStart, vsEnd;
  logic [1:0]  pwrState;
  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  lcd_raster_timer u_lcd_raster_timer (
    .clk(clk), .rstN(rstN), .runReq(runReq), .syncPol(syncPol),
    .horizWord(horizWord), .hsyncWord(hsyncWord),
    .vertWord(vertWord), .vsyncWord(vsyncWord),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut),
    .frameStart(frameStart), .vsStart(vsStart), .vsEnd(vsEnd),
    .pwrState(pwrState)
  );

  // observed bits: {hsync, vsync, de, frameStart, vsStart, vsEnd}
  function automatic logic [5:0] obs();
    return {hsyncOut, vsyncOut, deOut, frameStart, vsStart, vsEnd};
  endfunction

  task automatic chk(input string tag, input logic [5:0] got, input logic [5:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic chkPwr(input string tag, input logic [1:0] exp);
    nChecks++;
    if (pwrState !== exp) begin
      nFails++;
      $display("FAIL %s: pwrState got %0d expected %0d", tag, pwrState, exp);
    end
  endtask

  // Geometry A: 24 dots/line, 16 active, hsync dots 16..23,
  // 6 lines, 3 active, vsync on line 4 only. Position = line*24 + dot.
  localparam int NVEC = 12;
  localparam logic [13:0] VEC [NVEC] = '{
    {8'd0,   6'b001100},  // R3 R4 frame start, enable on
    {8'd15,  6'b001000},  // R4 last active dot
    {8'd16,  6'b100000},  // R5 hsync begins, enable off
    {8'd23,  6'b100000},  // R2 R5 last dot of line
    {8'd24,  6'b001000},  // R2 next line dot 0
    {8'd58,  6'b001000},  // R4 line 2 dot 10
    {8'd72,  6'b000000},  // R4 line 3 below active lines
    {8'd88,  6'b100000},  // R5 hsync in blank line
    {8'd96,  6'b010010},  // R6 R7 vsync start
    {8'd116, 6'b110000},  // R5 R6 both syncs
    {8'd120, 6'b000001},  // R7 vsync end
    {8'd144, 6'b001100}   // R3 next frame start
  };

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int cur;
    horizWord = {16'd2, 16'd3};
    hsyncWord = {16'd1, 16'd2};
    vertWord  = {16'd3, 16'd6};
    vsyncWord = {16'd1, 16'd4};

    repeat (3) @(negedge clk);
    chk("R10 reset outputs", obs(), 6'b000000);
    chkPwr("R10 reset power", 2'b00);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle outputs", obs(), 6'b000000);
    chkPwr("R1 idle power", 2'b00);

    runReq = 1'b1;
    @(negedge clk);
    chkPwr("R1 running power", 2'b11);
    cur = 0;
    for (int i = 0; i < NVEC; i++) begin
      int pos;
      pos = int'(VEC[i][13:6]);
      repeat (pos - cur) @(negedge clk);
      cur = pos;
      chk($sformatf("R2 R3 R4 R5 R6 R7 vector %0d", i), obs(), VEC[i][5:0]);
    end

    // now at frame 2 position 0: change polarity mid-stream
    syncPol = 3'b111;
    repeat (96) @(negedge clk);
    chk("R9 polarity not applied mid-frame", obs(), 6'b010010);
    repeat (48) @(negedge clk);
    chk("R8 inverted at frame start", obs(), 6'b110100);
    repeat (96) @(negedge clk);
    chk("R8 inverted vsync line", obs(), 6'b101010);

    runReq = 1'b0;
    @(negedge clk);
    chkPwr("R1 stopped power", 2'b00);
    chk("R1 R8 stopped idle levels", obs(), 6'b111000);
    repeat (5) @(negedge clk);
    chk("R1 no events while stopped", obs(), 6'b111000);

    // Geometry B: 16 dots/line, 8 active; latched at restart
    horizWord = {16'd1, 16'd2};
    syncPol   = 3'b000;
    runReq    = 1'b1;
    @(negedge clk);
    chk("R9 new geometry frame start", obs(), 6'b001100);
    repeat (8) @(negedge clk);
    chk("R4 enable ends at dot 8", obs(), 6'b000000);
    repeat (8) @(negedge clk);
    chk("R2 line wraps at dot 16", obs(), 6'b001000);
    repeat (48) @(negedge clk);
    chk("R6 R7 vsync start geometry B", obs(), 6'b010010);
    repeat (32) @(negedge clk);
    chk("R3 frame of 96 dots", obs(), 6'b001100);

    finishRun();
  end
endmodule